// File: doc/BRIEF.md
# Board Bring-Up and Firmware Download Sequencer

This block is a host-side master that takes a serial I/O board from reset to running firmware. It reaches the board through a byte-wide register port with eight offsets. A single `start` pulse launches the whole sequence. The block writes the reset offset twice, with a programmable pause between the two writes. It then polls the status offset until the inbound side holds data, and reads the sixteen-byte power-on message one byte at a time. Each identification byte is checked the moment it arrives. The block also keeps the descriptor fields that later driver code needs.

After the message, firmware image bytes flow in on a valid/ready stream and are written to the data offset in fixed-size blocks. Before each byte the block reads the outbound-full status bit. The very first image byte must carry a tag value, or nothing is sent. Once the last block is out, the block waits for one answer byte from the board and reports success or a fault code.

All waits are measured with a single millisecond tick that comes from a clock prescaler. Every phase has its own limit, and the first block gets a longer allowance than the blocks after it.

Top module: `boot_seq_top`

## Requirements
- R1: After a synchronous reset the block is idle. `busy`, `done`, `err`, `bus_rd`, `bus_wr` and `img_ready` are all 0.
- R2: A start issues exactly two writes to offset 7, never in adjacent cycles. The second write strobe comes exactly GAP_MS*TICK_DIV+2 clock cycles after the first.
- R3: The block reads offset 2 and reads offset 0 only after a status value whose bit 5 (inbound empty) is clear. If the message has not started within POR_MS ticks of the second reset write, the block stops with `err_code` 1.
- R4: Message byte 0 must be 0x96 and byte 1 must be 0x35. On a mismatch no further data byte is read, and the block stops with `err_code` 2.
- R5: `family` is message byte 5 bits [7:6]. When `family` is 01, `bus_kind` is byte 6 bits [2:0], `slot16` is byte 6 bit 5, `dip16` is byte 6 bit 4, `fifo_log2` is byte 14 and `box_count` is byte 15. For any other family these five outputs are 0.
- R6: If the first byte of the first block is not 0x3C, the block writes nothing to offset 0 and stops with `err_code` 3.
- R7: `num_blocks`*BLK_BYTES image bytes are written to offset 0 in stream order. A write is made only after a status read whose bit 6 (outbound full) is clear. A byte is taken from the stream only in the cycle it is written.
- R8: Each block must complete within a limit counted from its start. The limit is FIRST_MS ticks for the first block and NEXT_MS ticks for later blocks, and it includes outbound-full stalls. An overrun stops the block with `err_code` 4.
- R9: After the last block the block reads one answer byte. 0xC3 sets `done`, 0x5A gives `err_code` 5, any other value gives `err_code` 6, and no answer within ACK_MS ticks gives `err_code` 7.
- R10: `done` and `err` are never both set, and they stay set until the next start. A start while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the sequence (taken when not busy) |
| num_blocks | input | 8 | Number of image blocks, sampled at start |
| img_data | input | 8 | Image stream byte |
| img_valid | input | 1 | Image byte present |
| img_ready | output | 1 | Image byte taken this cycle |
| bus_addr | output | 3 | Register offset on the board port |
| bus_rd | output | 1 | Read strobe, data sampled in the same cycle |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid while `bus_rd` is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished with good answer |
| err | output | 1 | Sequence stopped on a fault |
| err_code | output | 3 | Fault code (0 none, 1..7 per R3..R9) |
| family | output | 2 | Product family field |
| bus_kind | output | 3 | Bus type field (expandable family) |
| slot16 | output | 1 | Wide-slot flag (expandable family) |
| dip16 | output | 1 | Wide-mode switch flag (expandable family) |
| fifo_log2 | output | 8 | Log2 of board FIFO size (expandable family) |
| box_count | output | 8 | Attached box count (expandable family) |

## Verification
The assertions assume that the read data is a combinational answer to the current offset, which lets the block decide in the same cycle as its strobe. They also assume that `num_blocks` is at least 1 when a start is accepted. The bench board model meets both conditions. It answers offsets 0 and 2 from its own queue and full flags without delay. Every run sets one to three blocks, and a random outbound-full pattern and a random stream-valid pattern are drawn from a seeded generator.

// File: rtl/boot_seq_pkg.sv
// Shared constants and types for the board bring-up sequencer.
// Assumes a byte-wide register port with 3-bit offsets.
package boot_seq_pkg;
    localparam int MSG_LEN = 16;
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd2;
    localparam logic [2:0] OFS_RESET = 3'd7;
    localparam int BIT_IN_EMPTY = 5;
    localparam int BIT_OUT_FULL = 6;
    localparam logic [7:0] ID_BYTE0 = 8'h96;
    localparam logic [7:0] ID_BYTE1 = 8'h35;
    localparam logic [7:0] IMG_TAG  = 8'h3C;
    localparam logic [7:0] ANS_GOOD = 8'hC3;
    localparam logic [7:0] ANS_CRC  = 8'h5A;
    localparam logic [1:0] FAM_EXP  = 2'b01;

    typedef enum logic [2:0] {
        F_NONE, F_POR_TMO, F_ID, F_IMG_TAG, F_BLK_TMO, F_CRC, F_ANS_BAD, F_ANS_TMO
    } fault_t;

    typedef enum logic [3:0] {
        P_IDLE, P_RST1, P_GAP, P_RST2, P_POR_ST, P_POR_RD,
        P_DL_ST, P_DL_WR, P_ANS_ST, P_ANS_RD, P_DONE, P_FAIL
    } phase_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/boot_ms_tick.sv
// Millisecond tick prescaler: pulses tick once every DIV clocks.
// Assumes clr restarts the count so a phase starts on a tick boundary.
module boot_ms_tick #(
    parameter int DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [PW-1:0] pre;

    assign tick = (pre == PW'(DIV - 1));

    // Count clocks up to DIV-1, then wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre <= '0;
        else if (tick)     pre <= '0;
        else               pre <= pre + 1'b1;
    end
endmodule

// File: rtl/boot_ms_timer.sv
// Phase timer: counts ticks since clr and flags when the limit is reached.
// Assumes limit is steady within a phase; count stops at the limit.
module boot_ms_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt >= limit);

    // Advance on each tick until the limit is met
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        cnt <= '0;
        else if (tick && !expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/boot_por_fields.sv
// Captures descriptor bytes of the power-on message by index and decodes them.
// Assumes bytes arrive with their index; wide-family fields are gated by family.
module boot_por_fields
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cap,
    input  logic [3:0] idx,
    input  logic [7:0] rd_byte,
    output logic [1:0] family,
    output logic [2:0] bus_kind,
    output logic       slot16,
    output logic       dip16,
    output logic [7:0] fifo_log2,
    output logic [7:0] box_count
);
    logic [7:0] id_q, busb_q, fifo_q, box_q;
    logic       wide;

    // Latch the four descriptor bytes as they stream past
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            id_q <= '0; busb_q <= '0; fifo_q <= '0; box_q <= '0;
        end else if (cap) begin
            case (idx)
                4'd5:    id_q   <= rd_byte;
                4'd6:    busb_q <= rd_byte;
                4'd14:   fifo_q <= rd_byte;
                4'd15:   box_q  <= rd_byte;
                default: ;
            endcase
        end
    end

    assign family    = id_q[7:6];
    assign wide      = (family == FAM_EXP);
    assign bus_kind  = wide ? busb_q[2:0] : 3'd0;
    assign slot16    = wide & busb_q[5];
    assign dip16     = wide & busb_q[4];
    assign fifo_log2 = wide ? fifo_q : 8'd0;
    assign box_count = wide ? box_q  : 8'd0;
endmodule

// File: rtl/boot_seq_top.sv
// Board bring-up sequencer: double reset, power-on message read and check,
// block-wise image download with tag check, and final answer decode.
// Assumes bus_rdata is valid in the same cycle as bus_rd and num_blocks >= 1.
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int TICK_DIV  = 125000,
    parameter int GAP_MS    = 50,
    parameter int POR_MS    = 2000,
    parameter int FIRST_MS  = 1000,
    parameter int NEXT_MS   = 100,
    parameter int ANS_MS    = 100,
    parameter int BLK_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] num_blocks,
    input  logic [7:0] img_data,
    input  logic       img_valid,
    output logic       img_ready,
    output logic [2:0] bus_addr,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [2:0] err_code,
    output logic [1:0] family,
    output logic [2:0] bus_kind,
    output logic       slot16,
    output logic       dip16,
    output logic [7:0] fifo_log2,
    output logic [7:0] box_count
);
    localparam int MAX_MS = max_of(max_of(max_of(GAP_MS, POR_MS), max_of(FIRST_MS, NEXT_MS)), ANS_MS);
    localparam int LW = $clog2(MAX_MS + 1);
    localparam int BW = $clog2(BLK_BYTES);

    phase_t       ph, ph_d;
    fault_t       fault_q, fault_d;
    logic [3:0]   idx;
    logic [BW-1:0] bcnt;
    logic [7:0]   blk, nblk_q;
    logic         tick, tmo, tclr, cap, fclr;
    logic [LW-1:0] limit;
    logic         tag_bad, last_byte, last_blk, wr_go, accept;

    assign accept    = start && (ph == P_IDLE || ph == P_DONE || ph == P_FAIL);
    assign tag_bad   = (blk == 8'd0) && (bcnt == '0) && (img_data != IMG_TAG);
    assign last_byte = (bcnt == BW'(BLK_BYTES - 1));
    assign last_blk  = (blk == nblk_q - 8'd1);
    assign wr_go     = (ph == P_DL_WR) && !tmo && img_valid && !tag_bad;
    assign fclr      = accept;

    boot_ms_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .tick(tick)
    );

    boot_ms_timer #(.W(LW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .tick(tick), .limit(limit), .expired(tmo)
    );

    boot_por_fields u_fields (
        .clk(clk), .rst_n(rst_n), .clr(fclr), .cap(cap), .idx(idx), .rd_byte(bus_rdata),
        .family(family), .bus_kind(bus_kind), .slot16(slot16), .dip16(dip16),
        .fifo_log2(fifo_log2), .box_count(box_count)
    );

    // Select the time allowance of the current phase
    always_comb begin
        case (ph)
            P_GAP:              limit = LW'(GAP_MS);
            P_POR_ST, P_POR_RD: limit = LW'(POR_MS);
            P_DL_ST, P_DL_WR:   limit = (blk == 8'd0) ? LW'(FIRST_MS) : LW'(NEXT_MS);
            P_ANS_ST, P_ANS_RD: limit = LW'(ANS_MS);
            default:            limit = '0;
        endcase
    end

    // Phase sequencing and bus strobes
    always_comb begin
        ph_d = ph; fault_d = fault_q;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = OFS_DATA; bus_wdata = 8'h00;
        img_ready = 1'b0; tclr = 1'b0; cap = 1'b0;
        case (ph)
            P_IDLE, P_DONE, P_FAIL:
                if (start) begin ph_d = P_RST1; fault_d = F_NONE; end
            P_RST1: begin
                bus_wr = 1'b1; bus_addr = OFS_RESET; tclr = 1'b1; ph_d = P_GAP;
            end
            P_GAP:
                if (tmo) ph_d = P_RST2;
            P_RST2: begin
                bus_wr = 1'b1; bus_addr = OFS_RESET; tclr = 1'b1; ph_d = P_POR_ST;
            end
            P_POR_ST: begin
                bus_rd = 1'b1; bus_addr = OFS_STAT;
                if (!bus_rdata[BIT_IN_EMPTY]) ph_d = P_POR_RD;
                else if (tmo) begin ph_d = P_FAIL; fault_d = F_POR_TMO; end
            end
            P_POR_RD: begin
                bus_rd = 1'b1; cap = 1'b1;
                if ((idx == 4'd0 && bus_rdata != ID_BYTE0) ||
                    (idx == 4'd1 && bus_rdata != ID_BYTE1)) begin
                    ph_d = P_FAIL; fault_d = F_ID;
                end else if (idx == 4'(MSG_LEN - 1)) begin
                    ph_d = P_DL_ST; tclr = 1'b1;
                end else ph_d = P_POR_ST;
            end
            P_DL_ST: begin
                bus_rd = 1'b1; bus_addr = OFS_STAT;
                if (!bus_rdata[BIT_OUT_FULL]) ph_d = P_DL_WR;
                else if (tmo) begin ph_d = P_FAIL; fault_d = F_BLK_TMO; end
            end
            P_DL_WR: begin
                if (tmo) begin
                    ph_d = P_FAIL; fault_d = F_BLK_TMO;
                end else if (img_valid && tag_bad) begin
                    ph_d = P_FAIL; fault_d = F_IMG_TAG;
                end else if (img_valid) begin
                    bus_wr = 1'b1; bus_wdata = img_data; img_ready = 1'b1;
                    ph_d = P_DL_ST;
                    if (last_byte) begin
                        tclr = 1'b1;
                        if (last_blk) ph_d = P_ANS_ST;
                    end
                end
            end
            P_ANS_ST: begin
                bus_rd = 1'b1; bus_addr = OFS_STAT;
                if (!bus_rdata[BIT_IN_EMPTY]) ph_d = P_ANS_RD;
                else if (tmo) begin ph_d = P_FAIL; fault_d = F_ANS_TMO; end
            end
            P_ANS_RD: begin
                bus_rd = 1'b1;
                if (bus_rdata == ANS_GOOD)     ph_d = P_DONE;
                else begin
                    ph_d = P_FAIL;
                    fault_d = (bus_rdata == ANS_CRC) ? F_CRC : F_ANS_BAD;
                end
            end
            default: ph_d = P_IDLE;
        endcase
    end

    // State, message index and block/byte counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= P_IDLE; fault_q <= F_NONE; idx <= '0; bcnt <= '0;
            blk <= '0; nblk_q <= '0;
        end else begin
            ph <= ph_d; fault_q <= fault_d;
            if (accept) nblk_q <= num_blocks;
            if (ph == P_RST2)        idx <= '0;
            else if (ph == P_POR_RD) idx <= idx + 1'b1;
            if (ph == P_RST2) begin
                bcnt <= '0; blk <= '0;
            end else if (wr_go) begin
                bcnt <= last_byte ? '0 : bcnt + 1'b1;
                if (last_byte && !last_blk) blk <= blk + 8'd1;
            end
        end
    end

    assign busy     = !(ph == P_IDLE || ph == P_DONE || ph == P_FAIL);
    assign done     = (ph == P_DONE);
    assign err      = (ph == P_FAIL);
    assign err_code = fault_q;
endmodule

// File: rtl/boot_seq_chk.sv
// Port-level checker for the bring-up sequencer, bound to every instance.
// Assumes combinational read data and num_blocks >= 1 on an accepted start.
module boot_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       img_valid,
    input logic       img_ready,
    input logic [2:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       busy,
    input logic       done,
    input logic       err
);
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R3: reads only touch status or data
    assert_rd_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr == 3'd0 || bus_addr == 3'd2));
    assert_wr_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == 3'd0 || bus_addr == 3'd7));
    assert_reset_not_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd7) |=> !(bus_wr && bus_addr == 3'd7));
    assert_take_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> (img_valid && bus_wr && bus_addr == 3'd0));
    assert_write_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |-> img_ready);
    assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err) && !(busy && (done || err)));
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
    assert_done_after_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_rd && bus_addr == 3'd0));
endmodule

bind boot_seq_top boot_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .img_valid(img_valid),
    .img_ready(img_ready), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .busy(busy), .done(done), .err(err)
);

// File: tb/boot_seq_top_tb.sv
// Bench: board model on the register port plus a seeded image stream.
module boot_seq_top_tb;
    localparam int TD = 4, GAP = 3, PORL = 20, FIRST = 80, NEXT = 30, ANSL = 10, BLK = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] nblocks = 8'd1;
    logic [7:0] img_data;
    logic img_valid, img_ready, bus_rd, bus_wr, busy, done, err, slot16, dip16;
    logic [2:0] bus_addr, err_code, bus_kind;
    logic [7:0] bus_wdata, bus_rdata, fifo_log2, box_count;
    logic [1:0] family;

    int n_chk = 0, n_err = 0;
    // model configuration (written by tasks only)
    logic model_clr = 1'b0, hdr_ok = 1'b1, ans_en = 1'b1;
    logic [7:0] ans_val = 8'hC3;
    logic [7:0] msg [16];
    int por_delay = 30, ans_delay = 5, exp_bytes = 0, rseed = 7;
    int full_pct = 20, stall_at = -1, stall_len = 0;
    // model state (written by the model process only)
    logic [7:0] q [32];
    logic [7:0] wr_log [64];
    int head, tail, n_rst, n_rd0, n_wr0, viol, t1, t2, cyc, por_cnt, ans_cnt, stall_cnt, sidx;
    logic por_arm, ans_done, rand_full, full_seen;
    logic out_full, in_empty;

    always #4 clk = ~clk;

    boot_seq_top #(.TICK_DIV(TD), .GAP_MS(GAP), .POR_MS(PORL), .FIRST_MS(FIRST),
                   .NEXT_MS(NEXT), .ANS_MS(ANSL), .BLK_BYTES(BLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_blocks(nblocks),
        .img_data(img_data), .img_valid(img_valid), .img_ready(img_ready),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err), .err_code(err_code),
        .family(family), .bus_kind(bus_kind), .slot16(slot16), .dip16(dip16),
        .fifo_log2(fifo_log2), .box_count(box_count)
    );

    function automatic logic [7:0] img_byte(input int k, input logic ok, input int sd);
        if (k == 0) return ok ? 8'h3C : 8'h3D;
        return 8'((k * 29 + sd) ^ (k >> 2));
    endfunction

    assign img_data = img_byte(sidx, hdr_ok, rseed);
    assign in_empty = (head == tail);
    assign out_full = rand_full || (n_wr0 == stall_at && stall_cnt < stall_len);
    assign bus_rdata = (bus_addr == 3'd2) ? {1'b0, out_full, in_empty, 5'b0} :
                       (bus_addr == 3'd0) ? (in_empty ? 8'h00 : q[head[4:0]]) : 8'hFF;

    // Board model and image stream source
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (model_clr) begin
            head <= 0; tail <= 0; n_rst <= 0; n_rd0 <= 0; n_wr0 <= 0; viol <= 0;
            por_arm <= 1'b0; por_cnt <= 0; ans_cnt <= 0; ans_done <= 1'b0;
            stall_cnt <= 0; sidx <= 0; img_valid <= 1'b0; rand_full <= 1'b0; full_seen <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == 3'd7) begin
                n_rst <= n_rst + 1;
                if (n_rst == 0) t1 <= cyc; else t2 <= cyc;
                head <= 0; tail <= 0; por_arm <= (n_rst == 1); por_cnt <= 0;
            end else if (por_arm) begin
                if (por_delay >= 0 && por_cnt == por_delay) begin
                    for (int i = 0; i < 16; i++) q[i] <= msg[i];
                    head <= 0; tail <= 16; por_arm <= 1'b0;
                end else por_cnt <= por_cnt + 1;
            end else if (n_wr0 == exp_bytes && exp_bytes > 0 && ans_en && !ans_done) begin
                if (ans_cnt == ans_delay) begin
                    q[tail[4:0]] <= ans_val; tail <= tail + 1; ans_done <= 1'b1;
                end else ans_cnt <= ans_cnt + 1;
            end
            if (bus_rd && bus_addr == 3'd0) begin
                n_rd0 <= n_rd0 + 1;
                if (head == tail) viol <= viol + 1; else head <= head + 1;
            end
            if (bus_rd && bus_addr == 3'd2) full_seen <= out_full;
            if (bus_wr && bus_addr == 3'd0) begin
                if (full_seen) viol <= viol + 1;
                if (n_wr0 < 64) wr_log[n_wr0] <= bus_wdata;
                n_wr0 <= n_wr0 + 1;
            end
            if (n_wr0 == stall_at) stall_cnt <= stall_cnt + 1;
            if (img_valid && img_ready) sidx <= sidx + 1;
            if (!img_valid || img_ready) img_valid <= (($urandom % 100) < 75);
            rand_full <= (($urandom % 100) < full_pct);
        end
    end

    initial begin cyc = 0; head = 0; tail = 0; n_wr0 = 0; stall_cnt = 0; sidx = 0; end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_msg(input logic [1:0] fam, input logic [7:0] b6, input logic [7:0] b14,
                           input logic [7:0] b15, input logic [7:0] m0, input logic [7:0] m1);
        for (int i = 0; i < 16; i++) msg[i] = 8'($urandom);
        msg[0] = m0; msg[1] = m1; msg[5] = {fam, 6'($urandom)}; msg[6] = b6;
        msg[14] = b14; msg[15] = b15;
    endtask

    task automatic run(input int nblk, input logic extra_start);
        int waited;
        @(negedge clk); model_clr = 1'b1; exp_bytes = nblk * BLK;
        @(negedge clk); model_clr = 1'b0;
        nblocks = 8'(nblk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        waited = 0;
        while (!(done || err) && waited < 6000) begin
            @(negedge clk); waited++;
            if (waited == 20 && extra_start) begin
                start = 1'b1; @(negedge clk); start = 1'b0; waited++;
            end
        end
        chk("R10 run ends in done or err", int'(done || err), 1);
    endtask

    task automatic chk_fields(input logic [1:0] fam, input logic [7:0] b6,
                              input logic [7:0] b14, input logic [7:0] b15);
        logic w;
        w = (fam == 2'b01);
        chk("R5 family", family, fam);
        chk("R5 bus_kind", bus_kind, w ? b6[2:0] : 0);
        chk("R5 slot16", slot16, w ? b6[5] : 0);
        chk("R5 dip16", dip16, w ? b6[4] : 0);
        chk("R5 fifo_log2", fifo_log2, w ? b14 : 0);
        chk("R5 box_count", box_count, w ? b15 : 0);
    endtask

    function automatic int img_mismatch(input int n);
        int m = 0;
        for (int i = 0; i < n && i < 64; i++)
            if (wr_log[i] !== img_byte(i, hdr_ok, rseed)) m++;
        return m;
    endfunction

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_clr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; model_clr = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
        chk("R1 strobes", int'(bus_rd || bus_wr), 0); chk("R1 img_ready", img_ready, 0);

        // Directed: expandable family, three blocks, good answer (R2 R3 R5 R7 R9)
        set_msg(2'b01, 8'h33, 8'd9, 8'd3, 8'h96, 8'h35);
        ans_val = 8'hC3; run(3, 1'b0);
        chk("R9 done on good answer", done, 1); chk("R9 code", err_code, 0);
        chk("R2 reset writes", n_rst, 2);
        chk("R2 reset gap cycles", t2 - t1, GAP * TD + 2);
        chk("R7 bytes written", n_wr0, 3 * BLK);
        chk("R7 stream order", img_mismatch(n_wr0), 0);
        chk("R3 R7 no empty read or full write", viol, 0);
        chk_fields(2'b01, 8'h33, 8'd9, 8'd3);

        // Older family, descriptor bytes set but must read as zero; CRC answer
        set_msg(2'b00, 8'hFF, 8'd7, 8'd4, 8'h96, 8'h35);
        ans_val = 8'h5A; run(1, 1'b0);
        chk("R9 crc code", err_code, 5); chk("R9 err set", err, 1);
        chk_fields(2'b00, 8'hFF, 8'd7, 8'd4);
        chk("R7 one block written", n_wr0, BLK);

        // Identification mismatch on byte 0 and on byte 1 (R4)
        set_msg(2'b01, 8'h00, 8'd1, 8'd1, 8'h97, 8'h35); run(1, 1'b0);
        chk("R4 code byte0", err_code, 2); chk("R4 reads byte0", n_rd0, 1);
        chk("R4 no writes", n_wr0, 0);
        set_msg(2'b01, 8'h00, 8'd1, 8'd1, 8'h96, 8'h36); run(1, 1'b0);
        chk("R4 code byte1", err_code, 2); chk("R4 reads byte1", n_rd0, 2);

        // Bad image tag (R6)
        set_msg(2'b01, 8'h21, 8'd5, 8'd2, 8'h96, 8'h35);
        hdr_ok = 1'b0; ans_val = 8'hC3; run(2, 1'b0);
        chk("R6 code", err_code, 3); chk("R6 no data writes", n_wr0, 0);
        hdr_ok = 1'b1;

        // Message never arrives (R3)
        por_delay = -1; run(1, 1'b0);
        chk("R3 por timeout code", err_code, 1); chk("R3 no data reads", n_rd0, 0);
        por_delay = 30;

        // Long stall inside first block fits its larger allowance (R8)
        full_pct = 0; stall_at = 3; stall_len = 170; run(2, 1'b0);
        chk("R8 first block stall tolerated", done, 1);
        // Same stall in a later block overruns (R8)
        stall_at = BLK + 3; run(2, 1'b0);
        chk("R8 later block timeout code", err_code, 4);
        chk("R8 writes stop at stall", n_wr0, BLK + 3);
        stall_at = -1; stall_len = 0; full_pct = 20;

        // Unknown answer and missing answer (R9)
        ans_val = 8'h77; run(1, 1'b0); chk("R9 unknown answer code", err_code, 6);
        ans_val = 8'hC3; ans_en = 1'b0; run(1, 1'b0); chk("R9 answer timeout code", err_code, 7);
        ans_en = 1'b1;

        // Start while busy is ignored (R10)
        run(1, 1'b1);
        chk("R10 restart ignored resets", n_rst, 2); chk("R10 still done", done, 1);
        repeat (5) @(negedge clk);
        chk("R10 done held", done, 1);

        // Random runs
        for (int r = 0; r < 5; r++) begin
            logic [1:0] f; logic [7:0] b6, b14, b15; int nb;
            f = 2'($urandom % 2); b6 = 8'($urandom); b14 = 8'($urandom % 16);
            b15 = 8'(1 + $urandom % 4); nb = 1 + $urandom % 3; rseed = $urandom % 256;
            set_msg(f, b6, b14, b15, 8'h96, 8'h35);
            run(nb, 1'b0);
            chk("R9 random done", done, 1);
            chk("R7 random bytes", n_wr0, nb * BLK);
            chk("R7 random order", img_mismatch(n_wr0), 0);
            chk("R3 R7 random protocol", viol, 0);
            chk_fields(f, b6, b14, b15);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule